// File: doc/BRIEF.md
# Input Pulse Suppression Filter

This block cleans up one digital input that has already been synchronized to the local clock. A change on the raw input reaches the filtered output only after the new level has been held without a break for a programmable number of clock cycles. Shorter pulses and glitches are removed completely. The hold time comes from a 10-bit preload value. An internal down counter is loaded from the preload and steps down once per clock while the raw input disagrees with the filtered output. The output takes the new level when the counter has reached zero and the disagreement is still present.

If the input falls back to the output level before that point, the counter is loaded again with the preload and the output does not move. The next disagreement then starts a complete new count. An enable bit bypasses the filter: with the bypass active, the output copies the input after one register stage. During reset the output register loads the current input level, so no false edge appears when reset is released. For a set of pins, place one instance per pin.

Top module: `glitch_filter`

## Requirements
- R1: While reset is low (synchronous, active low), each clock loads the raw input level into the filtered output. When reset is released, the output equals the input level sampled at the last reset edge and does not change on that release.
- R2: When the filter is enabled and the raw input equals the filtered output, the output keeps its level.
- R3: When the filter is enabled with preload P, the input differs from the output at P+1 consecutive clock edges, and P was the loaded count at the first of those edges, the output takes the input level at the (P+1)-th edge. It does not change at any earlier edge.
- R4: If the input returns to the output level before the (P+1)-th edge, the output stays unchanged. The count is reloaded, so a later mismatch again needs P+1 edges.
- R5: With preload 0, the output follows every input change with exactly one clock of latency.
- R6: With the enable bit at 0, the output equals the input sampled at the previous clock edge, whatever the preload is.
- R7: Writing a new preload value while a count is in progress does not change that count. The new value applies from the next reload, which happens on any cycle where input equals output, on a flip, or while the filter is bypassed.
- R8: The largest preload, 1023, gives a hold time of 1024 clock edges.
- R9: The filtered output only ever changes to the level that the raw input had at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter steps once per rising edge |
| rstN | input | 1 | Synchronous active-low reset; the output loads the input level |
| rawIn | input | 1 | Synchronized input to be filtered |
| preload | input | 10 | Hold time in cycles minus one |
| filtEn | input | 1 | 1 = filter active, 0 = output follows the input after one register |
| filtOut | output | 1 | Filtered level |

## Verification
If the counter holds a wrong value, the output edge shows up early or late against the hold window that the preload sets. A counter that was not reloaded after a short glitch shows up on the next real edge, which arrives sooner than P+1 cycles. A fault in the mismatch detection shows up at the ports within P+1 cycles of the first input change: either the output never moves, or it moves on a pulse it should have removed. A preset fault appears as a wrong level on the first cycle after reset.

// File: rtl/filt_pkg.sv
package filt_pkg;

  // Strobes issued by the control each cycle.
  typedef struct packed {
    logic reload;  // load counter from preload
    logic step;    // decrement counter
    logic take;    // copy raw input into filtered output
  } filtStrobeT;

endpackage

// File: rtl/filt_ctl.sv
module filt_ctl
  import filt_pkg::*;
(
  input  logic       filtEn,
  input  logic       mismatch,
  input  logic       cntZero,
  output filtStrobeT strb
);

  always_comb begin
    strb = '0;
    if (!filtEn) begin
      // bypass: follow input, keep counter primed
      strb.take   = 1'b1;
      strb.reload = 1'b1;
    end else if (!mismatch) begin
      // settled: counter waits at the preload
      strb.reload = 1'b1;
    end else if (cntZero) begin
      // held long enough: accept the new level, prime next count
      strb.take   = 1'b1;
      strb.reload = 1'b1;
    end else begin
      strb.step = 1'b1;
    end
  end

endmodule

// File: rtl/filt_dp.sv
module filt_dp
  import filt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawIn,
  input  logic [CNT_W-1:0] preload,
  input  filtStrobeT       strb,
  output logic             filtOut,
  output logic             mismatch,
  output logic             cntZero
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cntQ;
  logic             outQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outQ <= rawIn;
      cntQ <= preload;
    end else begin
      if (strb.take)
        outQ <= rawIn;
      if (strb.reload)
        cntQ <= preload;
      else if (strb.step)
        cntQ <= cntQ - CNT_ONE;
    end
  end

  assign filtOut  = outQ;
  assign mismatch = rawIn ^ outQ;
  assign cntZero  = (cntQ == '0);

endmodule

// File: rtl/glitch_filter.sv
module glitch_filter
  import filt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawIn,
  input  logic [CNT_W-1:0] preload,
  input  logic             filtEn,
  output logic             filtOut
);

  filtStrobeT strb;
  logic       mismatch;
  logic       cntZero;

  filt_ctl uCtl (
    .filtEn   (filtEn),
    .mismatch (mismatch),
    .cntZero  (cntZero),
    .strb     (strb)
  );

  filt_dp #(.CNT_W(CNT_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .rawIn    (rawIn),
    .preload  (preload),
    .strb     (strb),
    .filtOut  (filtOut),
    .mismatch (mismatch),
    .cntZero  (cntZero)
  );

endmodule

// File: rtl/filt_sva.sv
module filt_sva
  import filt_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       rawIn,
  input logic       filtEn,
  input logic       filtOut,
  input logic       mismatch,
  input logic       cntZero,
  input filtStrobeT strb
);

  // R2: settled input keeps the output
  assert_hold_when_equal_R2: assert property (@(posedge clk) disable iff (!rstN)
    filtEn && !mismatch |=> $stable(filtOut));

  // R4: mismatch with count remaining must not flip
  assert_no_early_flip_R4: assert property (@(posedge clk) disable iff (!rstN)
    filtEn && mismatch && !cntZero |=> $stable(filtOut));

  // R3: expired count with mismatch flips to the input level
  assert_flip_on_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    filtEn && mismatch && cntZero |=> filtOut == $past(rawIn));

  // R6: bypass copies input after one edge
  assert_bypass_follow_R6: assert property (@(posedge clk) disable iff (!rstN)
    !filtEn |=> filtOut == $past(rawIn));

  // R9: any output change lands on the sampled input level
  assert_change_to_input_R9: assert property (@(posedge clk) disable iff (!rstN)
    filtOut != $past(filtOut) |-> filtOut == $past(rawIn));

  // R3: control never steps and accepts in the same cycle
  assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.step && strb.take));

endmodule

bind glitch_filter filt_sva uSva (
  .clk      (clk),
  .rstN     (rstN),
  .rawIn    (rawIn),
  .filtEn   (filtEn),
  .filtOut  (filtOut),
  .mismatch (mismatch),
  .cntZero  (cntZero),
  .strb     (strb)
);

// File: tb/sim_glitch_filter.sv
`timescale 1ns/1ps
module sim_glitch_filter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rawIn = 1'b1;
  logic       filtEn = 1'b1;
  logic [9:0] preload = 10'd0;
  logic       filtOut;

  int  total = 0;
  int  bad = 0;
  bit  done = 0;
  logic       mOut = 1'b0;
  logic [9:0] mCnt = 10'd0;

  always #4 clk = ~clk;

  glitch_filter #(.CNT_W(10)) u0 (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   (rawIn),
    .preload (preload),
    .filtEn  (filtEn),
    .filtOut (filtOut)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // requirement-level reference, advanced once per edge
  function automatic void refStep();
    if (!rstN || !filtEn) begin
      mOut = rawIn;
      mCnt = preload;
    end else if (rawIn == mOut) begin
      mCnt = preload;
    end else if (mCnt == 10'd0) begin
      mOut = rawIn;
      mCnt = preload;
    end else begin
      mCnt = mCnt - 10'd1;
    end
  endfunction

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      refStep();
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd7321));
    // R1: preset to high level
    tick(3);
    rstN = 1'b1;
    check("R1 preset high", filtOut, 1'b1);
    tick();
    check("R1 no edge after release", filtOut, 1'b1);
    // R1: preset to low level
    rstN = 1'b0; rawIn = 1'b0;
    tick();
    rstN = 1'b1;
    check("R1 preset low", filtOut, 1'b0);

    // R3: P=5 needs 6 edges
    preload = 10'd5;
    tick(2);
    rawIn = 1'b1;
    tick(5);
    check("R3 before window end", filtOut, 1'b0);
    tick();
    check("R3 at window end", filtOut, 1'b1);

    // R4: glitch shorter than window, then a fresh full count
    rawIn = 1'b0;
    tick(5);
    rawIn = 1'b1;
    tick(10);
    check("R4 glitch removed", filtOut, 1'b1);
    rawIn = 1'b0;
    tick(5);
    check("R4 count restarted", filtOut, 1'b1);
    tick();
    check("R4 full count flips", filtOut, 1'b0);

    // R5: zero preload
    preload = 10'd0;
    tick();
    rawIn = 1'b1;
    tick();
    check("R5 rise one clock", filtOut, 1'b1);
    rawIn = 1'b0;
    tick();
    check("R5 fall one clock", filtOut, 1'b0);

    // R6: bypass
    filtEn = 1'b0; preload = 10'd9;
    rawIn = 1'b1;
    tick();
    check("R6 bypass rise", filtOut, 1'b1);
    rawIn = 1'b0;
    tick();
    check("R6 bypass fall", filtOut, 1'b0);
    filtEn = 1'b1;
    tick();

    // R7: preload change mid-count
    preload = 10'd8;
    tick();
    rawIn = 1'b1;
    tick(2);
    preload = 10'd2;
    tick(6);
    check("R7 old count kept", filtOut, 1'b0);
    tick();
    check("R7 old count expires", filtOut, 1'b1);
    rawIn = 1'b0;
    tick(2);
    check("R7 new preload pending", filtOut, 1'b1);
    tick();
    check("R7 new preload used", filtOut, 1'b0);

    // R8: largest preload
    preload = 10'd1023;
    tick();
    rawIn = 1'b1;
    tick(1023);
    check("R8 before 1024 edges", filtOut, 1'b0);
    tick();
    check("R8 at 1024 edges", filtOut, 1'b1);

    // random phase against the reference (R2 R9 R4 R3)
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(3) == 0) rawIn = ~rawIn;
      if ($urandom_range(63) == 0) preload = 10'($urandom_range(7));
      filtEn = ($urandom_range(31) != 0);
      rstN   = ($urandom_range(499) != 0);
      tick();
      check("R2 R9 random vs reference", filtOut, mOut);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule